// File: doc/BRIEF.md
# Buffer-to-Host Write Engine

This block moves one packet from a local receive buffer into host memory in answer to a receive-page command. The command carries a buffer index and a host qword address. The engine records both and points the buffer read port at the chosen buffer. It then waits until that buffer reports it holds data. When it does, the engine raises a host write request. The request carries the recorded address and the length the buffer reports.

The buffer always presents its head word, so the first data word is already on the write request when it appears. The write request's accept input drives the buffer read enable directly. Each accepted cycle consumes one buffer word and moves the data output on to the next word. When the done input arrives, the request is withdrawn. One cycle later a single-cycle completion pulse is produced, which the surrounding logic can use to raise an interrupt. While a command is pending or a transfer is in progress, further commands are ignored.

Top module: `host_write_engine`

## Requirements
- R1: While reset is applied, and until the first command, `wreq_valid`, `buf_rd_en` and `xfer_done` are low and `buf_sel` is 0.
- R2: A command seen at a clock edge while the engine is idle sets `buf_sel` to `cmd_buf` after that edge. `buf_sel` keeps that value after the transfer ends, until the next accepted command.
- R3: If bit `buf_sel` of `buf_ready` is high, `wreq_valid` rises one cycle after `buf_sel` changes. The request then shows `wreq_addr` equal to the commanded address, `wreq_len` equal to `buf_rd_len` sampled at that edge, and `wreq_data` equal to `buf_rd_data`.
- R4: While the request is up and `wreq_accept` is low, `buf_rd_en` is low and the request stays up with address, length and data unchanged.
- R5: While the request is up and `wreq_accept` is high, `buf_rd_en` is high and `wreq_data` advances to the next buffer word each cycle.
- R6: Within one transfer, `buf_rd_en` is high on at most `wreq_len` cycles. Once that count is reached it stays low even if `wreq_accept` is high.
- R7: `wreq_done` seen at an edge while the request is up drops `wreq_valid` and `buf_rd_en` after that edge. `xfer_done` is high for exactly the following cycle.
- R8: If the selected buffer's ready bit is low, the command stays pending with `wreq_valid` low until the bit rises. The request then starts one cycle later.
- R9: A command arriving while a command is pending, a transfer is in progress or completion is being signalled is ignored: `buf_sel`, address and the transfer in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Receive-page command strobe |
| cmd_buf | input | 4 | Buffer index of the command |
| cmd_addr | input | 61 | Host qword address of the command |
| buf_sel | output | 4 | Buffer read port select |
| buf_rd_en | output | 1 | Consume the current buffer word |
| buf_rd_data | input | 64 | Head word of the selected buffer |
| buf_rd_len | input | 9 | Length of the selected buffer in qwords |
| buf_ready | input | 16 | Per-buffer data-present bits |
| wreq_valid | output | 1 | Host write request active |
| wreq_addr | output | 61 | Host qword address of the write |
| wreq_len | output | 9 | Write length in qwords |
| wreq_data | output | 64 | Current write data word |
| wreq_accept | input | 1 | Host side takes the current word |
| wreq_done | input | 1 | Host side finished the write |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `wreq_done` is only raised while a request is up. They also assume that the selected buffer's length and head word do not change while the request waits for accept. The bench keeps to this in two ways. It pulses `wreq_done` only in cycles where its own model shows a transfer. It derives the buffer word from the buffer index and a pointer, and the pointer moves only on `buf_rd_en`. The stimulus covers a held-off accept, accept held past the buffer length, a pending command with its ready bit low, and commands issued while the engine is busy.

// File: rtl/hwe_pkg.sv
package hwe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_XFER = 2'd2,
    ST_FIN  = 2'd3
  } hwe_state_e;
endpackage

// File: rtl/hwe_rst_sync.sv
module hwe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/hwe_cmd_latch.sv
module hwe_cmd_latch #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_buf,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [IDX_W-1:0]  sel_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic [IDX_W-1:0]  sel_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    sel_d  = sel_q;
    addr_d = addr_q;
    if (cap_en) begin
      sel_d  = cap_buf;
      addr_d = cap_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      addr_q <= '0;
    end else begin
      sel_q  <= sel_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/hwe_beat_cnt.sv
module hwe_beat_cnt #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             beat,
  output logic [LEN_W-1:0] len_q,
  output logic             more
);
  logic [LEN_W-1:0] cnt_q, cnt_d, len_d;

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    if (load) begin
      cnt_d = '0;
      len_d = load_len;
    end else if (beat) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign more = (cnt_q < len_q);
endmodule

// File: rtl/hwe_ctrl.sv
module hwe_ctrl
  import hwe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic sel_ready,
  input  logic done,
  output logic cap_en,
  output logic start,
  output logic xfer,
  output logic fin_pulse
);
  hwe_state_e state_q, state_d;
  logic       pulse_d;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    start   = 1'b0;
    pulse_d = 1'b0;
    case (state_q)
      ST_IDLE: if (cmd_valid) begin
        cap_en  = 1'b1;
        state_d = ST_PEND;
      end
      ST_PEND: if (sel_ready) begin
        start   = 1'b1;
        state_d = ST_XFER;
      end
      ST_XFER: if (done) state_d = ST_FIN;
      ST_FIN: begin
        pulse_d = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      fin_pulse <= 1'b0;
    end else begin
      state_q   <= state_d;
      fin_pulse <= pulse_d;
    end
  end

  assign xfer = (state_q == ST_XFER);
endmodule

// File: rtl/host_write_engine.sv
module host_write_engine #(
  parameter int NUM_BUF = 16,
  parameter int DATA_W  = 64,
  parameter int LEN_W   = 9,
  parameter int ADDR_W  = 61,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [IDX_W-1:0]  cmd_buf,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [IDX_W-1:0]  buf_sel,
  output logic              buf_rd_en,
  input  logic [DATA_W-1:0] buf_rd_data,
  input  logic [LEN_W-1:0]  buf_rd_len,
  input  logic [NUM_BUF-1:0] buf_ready,
  output logic              wreq_valid,
  output logic [ADDR_W-1:0] wreq_addr,
  output logic [LEN_W-1:0]  wreq_len,
  output logic [DATA_W-1:0] wreq_data,
  input  logic              wreq_accept,
  input  logic              wreq_done,
  output logic              xfer_done
);
  logic rst_n_s, cap_en, start, xfer, more;

  hwe_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  hwe_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n_s), .cmd_valid(cmd_valid),
    .sel_ready(buf_ready[buf_sel]), .done(wreq_done),
    .cap_en(cap_en), .start(start), .xfer(xfer), .fin_pulse(xfer_done)
  );

  hwe_cmd_latch #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_cmd (
    .clk(clk), .rst_n(rst_n_s), .cap_en(cap_en), .cap_buf(cmd_buf),
    .cap_addr(cmd_addr), .sel_q(buf_sel), .addr_q(wreq_addr)
  );

  hwe_beat_cnt #(.LEN_W(LEN_W)) i_cnt (
    .clk(clk), .rst_n(rst_n_s), .load(start), .load_len(buf_rd_len),
    .beat(buf_rd_en), .len_q(wreq_len), .more(more)
  );

  assign wreq_valid = xfer;
  assign buf_rd_en  = xfer & wreq_accept & more;
  assign wreq_data  = xfer ? buf_rd_data : '0;
endmodule

// File: rtl/hwe_checker.sv
module hwe_checker #(
  parameter int NUM_BUF = 16,
  parameter int LEN_W   = 9,
  parameter int ADDR_W  = 61,
  parameter int IDX_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [IDX_W-1:0]  buf_sel,
  input logic [NUM_BUF-1:0] buf_ready,
  input logic              buf_rd_en,
  input logic              wreq_valid,
  input logic [ADDR_W-1:0] wreq_addr,
  input logic [LEN_W-1:0]  wreq_len,
  input logic              wreq_accept,
  input logic              wreq_done,
  input logic              xfer_done
);
  logic [LEN_W:0] beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           beats_q <= '0;
    else if (!wreq_valid) beats_q <= '0;
    else if (buf_rd_en)   beats_q <= beats_q + 1'b1;
  end

  a_r4_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !wreq_accept |-> !buf_rd_en);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wreq_valid && !wreq_accept && !wreq_done |=>
      wreq_valid && $stable(wreq_addr) && $stable(wreq_len));
  a_r6_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> ({1'b0, wreq_len} > beats_q));
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wreq_valid && wreq_done |=> !wreq_valid && !buf_rd_en);
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wreq_valid && wreq_done |-> ##2 xfer_done);
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  a_r8_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !wreq_valid && !buf_ready[buf_sel] |=> !wreq_valid);
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    wreq_valid && cmd_valid |=> $stable(buf_sel) && $stable(wreq_addr));
endmodule

bind host_write_engine hwe_checker #(
  .NUM_BUF(NUM_BUF), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) i_hwe_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .buf_sel(buf_sel),
  .buf_ready(buf_ready), .buf_rd_en(buf_rd_en), .wreq_valid(wreq_valid),
  .wreq_addr(wreq_addr), .wreq_len(wreq_len), .wreq_accept(wreq_accept),
  .wreq_done(wreq_done), .xfer_done(xfer_done)
);

// File: tb/test_host_write_engine.sv
module test_host_write_engine;
  logic        clk, rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_buf;
  logic [60:0] cmd_addr;
  logic [3:0]  buf_sel;
  logic        buf_rd_en;
  logic [63:0] buf_rd_data;
  logic [8:0]  buf_rd_len;
  logic [15:0] buf_ready;
  logic        wreq_valid;
  logic [60:0] wreq_addr;
  logic [8:0]  wreq_len;
  logic [63:0] wreq_data;
  logic        wreq_accept, wreq_done, xfer_done;

  host_write_engine i_host_write_engine (.*);

  int total = 0, bad = 0, cyc = 0;
  bit running = 0;

  // reference model state: 0 idle, 1 pending, 2 transfer, 3 finishing
  int m_state, m_sel, m_len, m_cnt, m_pulse;
  longint m_addr;
  int ptr;

  function automatic logic [63:0] word(int b, int p);
    return 64'hD5A0_0000_0000_0000 | (64'(b) << 16) | 64'(p);
  endfunction

  assign buf_rd_data = word(buf_sel, ptr);

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_state = 0; m_sel = 0; m_addr = 0; m_len = 0; m_cnt = 0; m_pulse = 0; ptr = 0;
    end else begin
      if (buf_rd_en) ptr++;
      m_pulse = 0;
      case (m_state)
        0: if (cmd_valid) begin m_sel = cmd_buf; m_addr = cmd_addr; m_state = 1; ptr = 0; end
        1: if (buf_ready[m_sel]) begin m_state = 2; m_len = buf_rd_len; m_cnt = 0; end
        2: begin
          if (wreq_accept && m_cnt < m_len) m_cnt++;
          if (wreq_done) m_state = 3;
        end
        default: begin m_pulse = 1; m_state = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (running) begin
      bit exp_en;
      exp_en = (m_state == 2) && wreq_accept && (m_cnt < m_len);
      chk(buf_sel == m_sel, "R2 buf_sel", buf_sel, m_sel);
      chk(wreq_valid == (m_state == 2), "R3/R8 wreq_valid", wreq_valid, m_state == 2);
      chk(buf_rd_en == exp_en, "R4/R5/R6 buf_rd_en", buf_rd_en, exp_en);
      chk(xfer_done == m_pulse, "R7 xfer_done", xfer_done, m_pulse);
      if (m_state == 2) begin
        chk(wreq_addr == m_addr, "R3 wreq_addr", wreq_addr, m_addr);
        chk(wreq_len == m_len, "R3 wreq_len", wreq_len, m_len);
        chk(wreq_data == word(m_sel, m_cnt), "R5 wreq_data", wreq_data, word(m_sel, m_cnt));
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic cmd(int b, longint a);
    cmd_valid = 1; cmd_buf = 4'(b); cmd_addr = 61'(a);
    step(); cmd_valid = 0;
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_buf = 0; cmd_addr = 0; buf_rd_len = 0;
    buf_ready = 0; wreq_accept = 0; wreq_done = 0;
    step(3);
    // R1: reset state
    chk(!wreq_valid && !buf_rd_en && !xfer_done, "R1 outputs idle", {wreq_valid, buf_rd_en, xfer_done}, 0);
    chk(buf_sel == 0, "R1 buf_sel", buf_sel, 0);
    rst_n = 1;
    step(4);
    running = 1;

    // Transfer 1: buffer 2, addr 31, length 3, accept held off then held past length (R4, R6)
    buf_ready = 16'h0004; buf_rd_len = 3;
    cmd(2, 31);
    step(3);
    cmd(9, 77);                       // R9: ignored during transfer
    wreq_accept = 1; step(4);         // 3 beats then one more cycle with no read (R6)
    wreq_accept = 0; wreq_done = 1; step(); wreq_done = 0;
    step(3);
    chk(buf_sel == 2, "R2 select held after transfer", buf_sel, 2);

    // Transfer 2: buffer 5 not ready -> pending (R8), extra command ignored (R9)
    buf_rd_len = 2;
    cmd(5, 4);
    step(2);
    cmd(7, 100);
    step(2);
    chk(!wreq_valid, "R8 pending while not ready", wreq_valid, 0);
    buf_ready[5] = 1; step(2);
    wreq_accept = 1; step(); wreq_accept = 0; step(); wreq_accept = 1; step();
    wreq_accept = 0; wreq_done = 1; step(); wreq_done = 0;
    cmd(3, 8);                        // R9: arrives during finishing cycle, ignored
    step(3);
    chk(buf_sel == 5, "R9 select unchanged", buf_sel, 5);

    // Transfer 3: length 1, accept and done together
    buf_ready = 16'h8000; buf_rd_len = 1;
    cmd(15, 61'h1234_5678);
    step(1);
    wreq_accept = 1; wreq_done = 1; step(); wreq_accept = 0; wreq_done = 0;
    step(4);

    running = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule